// File: doc/BRIEF.md
# Two-Level Word-Line Select Decoder

This block turns a row address into the select lines of a memory array that is split into sub-blocks. The address is cut into 2-bit pieces. Each piece is first expanded into a one-hot group of four lines. A word-line select is then the AND of one line taken from every group. With the default 10-bit address there are five groups, and each of the 1024 selects is a 5-input AND.

The array is divided into `NUM_BLK` sub-blocks, four by default. The uppermost address bits name the sub-block, and the bits below them give the row within it. A per-sub-block global line marks the addressed sub-block. The local lines of that sub-block carry the addressed row. Every sub-block that is not addressed raises its power-save flag.

An enable input blanks every select line and puts every sub-block into power-save. All outputs are registered, so the selection for an address sampled at one clock edge appears right after that edge. The design has no state machine: its only state is the output register, and it is either idle (enable low or in reset) or driving one selection.

Top module: `wl_hier_decoder`

## Requirements
- R1: While reset is asserted, every global and local line is 0 and every power-save flag is 1.
- R2: With enable high at a clock edge, exactly one local line is 1 after that edge. Its index equals the address sampled there, in the flat numbering sub-block × rows-per-sub-block + local row.
- R3: With enable high at a clock edge, exactly one global line is 1 after that edge. Its index is the value of the top log2(NUM_BLK) address bits sampled there.
- R4: With enable high, the power-save flags are the bitwise inverse of the global lines, so exactly one flag is 0.
- R5: With enable low at a clock edge, every global and local line is 0 and every power-save flag is 1 after that edge, whatever the address.
- R6: A high local line always lies inside the sub-block whose global line is high. The active local index divided by the rows per sub-block equals the active global index.
- R7: The outputs change only at a clock edge. An address change between edges leaves the outputs showing the previous selection until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Decode enable; low blanks all selects |
| row_addr | input | ADDR_W (10) | Row address; the top bits choose the sub-block |
| glb_wl | output | NUM_BLK (4) | Global line per sub-block, one-hot when enabled |
| loc_wl | output | 2**ADDR_W (1024) | Local word lines, flat index equals address |
| pwr_save | output | NUM_BLK (4) | Power-save flag per sub-block |

## Verification
The bound checker tests these properties on every cycle:
- the one-hot local selection and its match with the previous address;
- the global line against the previous block bits;
- the inverse relation between power-save flags and global lines;
- the all-idle pattern after a disabled edge;
- the nesting of the active local line inside its active sub-block.

Only the bench's scenarios show the rest:
- the full sweep of all 1024 addresses, reached through the ports;
- the values held in mid-cycle after an address change;
- the outputs during reset;
- the return from a disabled stretch to a new selection.

// File: rtl/wl_dec_pkg.sv
package wl_dec_pkg;
    // width of one address piece fed to a first-stage predecoder
    localparam int SEG_W = 2;
    // lines produced by one predecoder
    localparam int GRP_N = 1 << SEG_W;
endpackage

// File: rtl/wl_seg_predec.sv
module wl_seg_predec #(
    parameter int SEG_W = wl_dec_pkg::SEG_W
) (
    input  logic [SEG_W-1:0]      sel,
    output logic [(1<<SEG_W)-1:0] hot
);
    always_comb begin
        hot      = '0;
        hot[sel] = 1'b1;
    end
endmodule

// File: rtl/wl_predec_bank.sv
module wl_predec_bank #(
    parameter int ADDR_W = 10,
    parameter int SEG_W  = wl_dec_pkg::SEG_W
) (
    input  logic [ADDR_W-1:0]                         addr,
    output logic [(ADDR_W/SEG_W)*(1<<SEG_W)-1:0]      pre
);
    localparam int NSEG = ADDR_W / SEG_W;
    localparam int GRP  = 1 << SEG_W;

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        wl_seg_predec #(.SEG_W(SEG_W)) u_seg (
            .sel (addr[s*SEG_W +: SEG_W]),
            .hot (pre[s*GRP +: GRP])
        );
    end
endmodule

// File: rtl/wl_and_plane.sv
module wl_and_plane #(
    parameter int NSEG  = 5,
    parameter int SEG_W = wl_dec_pkg::SEG_W
) (
    input  logic [NSEG*(1<<SEG_W)-1:0]  pre,
    output logic [(1<<(NSEG*SEG_W))-1:0] wl
);
    localparam int GRP = 1 << SEG_W;
    localparam int NWL = 1 << (NSEG * SEG_W);

    // each select takes the group line picked by its own index bits
    always_comb begin
        logic acc;
        for (int w = 0; w < NWL; w++) begin
            acc = 1'b1;
            for (int s = 0; s < NSEG; s++) begin
                acc = acc & pre[s*GRP + ((w >> (s*SEG_W)) % GRP)];
            end
            wl[w] = acc;
        end
    end
endmodule

// File: rtl/wl_block_sel.sv
module wl_block_sel #(
    parameter int NUM_BLK = 4,
    parameter int BLK_W   = $clog2(NUM_BLK)
) (
    input  logic             en,
    input  logic [BLK_W-1:0] blk_addr,
    output logic [NUM_BLK-1:0] glb
);
    always_comb begin
        glb = '0;
        if (en) glb[blk_addr] = 1'b1;
    end
endmodule

// File: rtl/wl_hier_decoder.sv
module wl_hier_decoder #(
    parameter int ADDR_W  = 10,
    parameter int NUM_BLK = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [ADDR_W-1:0]       row_addr,
    output logic [NUM_BLK-1:0]      glb_wl,
    output logic [(1<<ADDR_W)-1:0]  loc_wl,
    output logic [NUM_BLK-1:0]      pwr_save
);
    localparam int SEG_W = wl_dec_pkg::SEG_W;
    localparam int GRP   = wl_dec_pkg::GRP_N;
    localparam int NSEG  = ADDR_W / SEG_W;
    localparam int NWL   = 1 << ADDR_W;
    localparam int BLK_W = $clog2(NUM_BLK);
    localparam int ROWS  = NWL / NUM_BLK;

    logic [NSEG*GRP-1:0] pre;
    logic [NWL-1:0]      wl_full;
    logic [NWL-1:0]      loc_nxt;
    logic [NUM_BLK-1:0]  blk_sel;

    wl_predec_bank #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_bank (
        .addr (row_addr),
        .pre  (pre)
    );

    wl_and_plane #(.NSEG(NSEG), .SEG_W(SEG_W)) u_plane (
        .pre (pre),
        .wl  (wl_full)
    );

    wl_block_sel #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) u_blk (
        .en       (en),
        .blk_addr (row_addr[ADDR_W-1 -: BLK_W]),
        .glb      (blk_sel)
    );

    // local line = full select gated by its own sub-block's global line
    always_comb begin
        for (int w = 0; w < NWL; w++) begin
            loc_nxt[w] = wl_full[w] & blk_sel[w / ROWS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glb_wl   <= '0;
            loc_wl   <= '0;
            pwr_save <= '1;
        end else begin
            glb_wl   <= blk_sel;
            loc_wl   <= loc_nxt;
            pwr_save <= ~blk_sel;
        end
    end
endmodule

// File: rtl/wl_hier_decoder_chk.sv
module wl_hier_decoder_chk #(
    parameter int ADDR_W  = 10,
    parameter int NUM_BLK = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   en,
    input logic [ADDR_W-1:0]      row_addr,
    input logic [NUM_BLK-1:0]     glb_wl,
    input logic [(1<<ADDR_W)-1:0] loc_wl,
    input logic [NUM_BLK-1:0]     pwr_save
);
    localparam int NWL   = 1 << ADDR_W;
    localparam int BLK_W = $clog2(NUM_BLK);
    localparam int ROWS  = NWL / NUM_BLK;
    localparam logic [NUM_BLK-1:0] ONE = {{(NUM_BLK-1){1'b0}}, 1'b1};

    AST_LOC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> ($countones(loc_wl) == 1)); // R2
    AST_LOC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> loc_wl[$past(row_addr)]); // R2
    AST_GLB_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (glb_wl == (ONE << $past(row_addr[ADDR_W-1 -: BLK_W])))); // R3
    AST_PS_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (pwr_save == ~glb_wl)); // R4
    AST_IDLE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (loc_wl == '0 && glb_wl == '0 && &pwr_save)); // R5
    AST_GLB_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(glb_wl)); // R6

    for (genvar b = 0; b < NUM_BLK; b++) begin : g_nest
        AST_LOC_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
            (|loc_wl[b*ROWS +: ROWS]) |-> glb_wl[b]); // R6
    end
endmodule

bind wl_hier_decoder wl_hier_decoder_chk #(.ADDR_W(ADDR_W), .NUM_BLK(NUM_BLK)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .row_addr (row_addr),
    .glb_wl   (glb_wl),
    .loc_wl   (loc_wl),
    .pwr_save (pwr_save)
);

// File: tb/sim_wl_hier_decoder.sv
`timescale 1ns/1ps
module sim_wl_hier_decoder;
    localparam int ADDR_W  = 10;
    localparam int NUM_BLK = 4;
    localparam int NWL     = 1 << ADDR_W;
    localparam int ROWS    = NWL / NUM_BLK;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [ADDR_W-1:0] row_addr = '0;
    logic [NUM_BLK-1:0] glb_wl;
    logic [NWL-1:0] loc_wl;
    logic [NUM_BLK-1:0] pwr_save;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wl_hier_decoder #(.ADDR_W(ADDR_W), .NUM_BLK(NUM_BLK)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .row_addr(row_addr),
        .glb_wl(glb_wl), .loc_wl(loc_wl), .pwr_save(pwr_save)
    );

    // index of the single set bit, -1 if not exactly one
    function automatic int hot_idx(input logic [NWL-1:0] v);
        int n = 0;
        int idx = -1;
        for (int i = 0; i < NWL; i++) if (v[i]) begin n++; idx = i; end
        return (n == 1) ? idx : -1;
    endfunction

    function automatic int glb_idx(input logic [NUM_BLK-1:0] v);
        int n = 0;
        int idx = -1;
        for (int i = 0; i < NUM_BLK; i++) if (v[i]) begin n++; idx = i; end
        return (n == 1) ? idx : -1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_sel(input int a, input string tag);
        chk(hot_idx(loc_wl) == a, {tag, " R2 local index"}, hot_idx(loc_wl), a);
        chk(glb_idx(glb_wl) == a / ROWS, {tag, " R3 global index"}, glb_idx(glb_wl), a / ROWS);
        chk(pwr_save == ~glb_wl, {tag, " R4 power-save"}, int'(pwr_save), int'(~glb_wl));
    endtask

    task automatic check_idle(input string tag);
        chk(loc_wl == '0, {tag, " local blank"}, hot_idx(loc_wl), -1);
        chk(glb_wl == '0, {tag, " global blank"}, int'(glb_wl), 0);
        chk(&pwr_save, {tag, " all power-save"}, int'(pwr_save), (1 << NUM_BLK) - 1);
    endtask

    task automatic drive(input bit e, input int a);
        @(negedge clk);
        en = e;
        row_addr = ADDR_W'(a);
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        en = 1'b1;
        row_addr = 10'd77;
        @(negedge clk);
        check_idle("R1 in reset");
        en = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_sweep();
        for (int a = 0; a < NWL; a++) begin
            drive(1'b1, a);
            check_sel(a, "sweep");
        end
    endtask

    task automatic t_corners();
        int lst[8] = '{0, NWL - 1, ROWS - 1, ROWS, 2*ROWS - 1, 2*ROWS, 3*ROWS, 682};
        foreach (lst[i]) begin
            drive(1'b1, lst[i]);
            chk(hot_idx(loc_wl) / ROWS == glb_idx(glb_wl), "R6 nested block",
                hot_idx(loc_wl) / ROWS, glb_idx(glb_wl));
            check_sel(lst[i], "corner");
        end
    endtask

    task automatic t_disable();
        drive(1'b1, 300);
        drive(1'b0, 300);
        check_idle("R5 disabled");
        drive(1'b0, NWL - 1);
        check_idle("R5 disabled new addr");
        drive(1'b1, 5);
        check_sel(5, "R5 re-enable");
    endtask

    task automatic t_latency();
        drive(1'b1, 129);
        check_sel(129, "R7 before change");
        row_addr = 10'd900;
        #2;
        chk(hot_idx(loc_wl) == 129, "R7 held mid-cycle", hot_idx(loc_wl), 129);
        @(negedge clk);
        chk(hot_idx(loc_wl) == 900, "R7 after edge", hot_idx(loc_wl), 900);
    endtask

    initial begin
        t_reset();
        t_sweep();
        t_corners();
        t_disable();
        t_latency();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule